// File: doc/BRIEF.md
# Prescaled Timer with Single-Edge PWM and Pin-Triggered Clear

The block is a free-running up-counter driven through a programmable prescaler. Three output channels each compare the count against their own compare value. A channel in PWM mode drives its pin high once the count reaches that value. The pin stays high until the count next returns to zero. A fourth compare value, the period, makes the counter wrap to zero. A channel outside PWM mode simply shows a software-written level bit.

Two asynchronous pins are synchronised inside the block. A programmable selection picks one edge, rising or falling, of one pin. When clearing is enabled, that edge zeroes the counter and the prescaler together. Software reaches every setting through a flat word-addressed write port and a combinational read port.

Register map (word addresses): 0 control (bit 0 run, bit 1 hold-at-zero), 1 prescale limit, 2/3/4 compare values of channels 0/1/2, 5 period, 6 PWM enables (bit i = channel i), 7 level bits for non-PWM channels (bit i = channel i), 8 clear setup (bit 0 enable, bits 3:1 edge select), 9 current count (read only), 10 current prescale count (read only).

Top module: `pwm_timer`

## Requirements
- R1: After reset every output is low, and every address from 0 to 10 reads zero.
- R2: While run is 1 and hold is 0, the count rises by one every (prescale limit + 1) clocks. While hold is 1, the count and the prescale count are held at zero.
- R3: On a count step taken while the count equals the period value, the count becomes 0 instead of period + 1. The count therefore runs 0..period.
- R4: A channel whose PWM enable bit is 1 drives its output high on the clock after the count equals its compare value.
- R5: A PWM output goes low in the same clock that the count is returned to zero, whether by a period wrap, by hold or by a pin clear. A compare value above the period keeps the output low. A compare value of 0 makes the output go high one clock after the count is zero.
- R6: A channel whose PWM enable bit is 0 drives the matching level bit of address 7, starting on the clock after that register is written.
- R7: With clear enable (address 8 bit 0) set, the edge select field (bits 3:1) picks the clear source. The codes are 0 = pin 0 rising, 1 = pin 0 falling, 2 = pin 1 rising, 3 = pin 1 falling. The chosen edge zeroes the count and the prescale count on the third rising clock edge after the pin changes.
- R8: With clear enable at 0, or with an edge select of 4 to 7, no pin edge disturbs the count.
- R9: Register bits without a function ignore writes and read back as zero.
- R10: Writable registers read back the value last written, at the address they were written to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per clock |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| cap_in | input | 2 | Asynchronous clear-source pins |
| mat_out | output | 3 | Channel outputs |

## Verification
A register write takes effect at the clock edge that samples it. A level bit shows on its output after that same edge. With the prescale limit at P, a count step happens once every P + 1 edges after run rises. A PWM output changes one edge after the count reaches its compare value, and it falls on the very edge that returns the count to zero. A pin change reaches the counter on the third edge after it, through two synchroniser flops and one history flop. The bench changes all inputs on falling clock edges. For each check it counts the exact number of rising edges from the stimulus and then samples on the next falling edge.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    localparam int CNT_W   = 32;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int N_CH    = 3;
    localparam int N_CAP   = 2;
    localparam int SYNC_N  = 2;
    localparam int SEL_W   = 3;
    localparam int N_SEL   = 2 ** SEL_W;

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_PRE    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_MATCH0 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_PER    = ADDR_W'(2 + N_CH);
    localparam logic [ADDR_W-1:0] A_PWM    = ADDR_W'(3 + N_CH);
    localparam logic [ADDR_W-1:0] A_LVL    = ADDR_W'(4 + N_CH);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(5 + N_CH);
    localparam logic [ADDR_W-1:0] A_CNT    = ADDR_W'(6 + N_CH);
    localparam logic [ADDR_W-1:0] A_PCNT   = ADDR_W'(7 + N_CH);

    typedef struct packed {
        logic                       run;
        logic                       hold;
        logic [CNT_W-1:0]           pre_lim;
        logic [CNT_W-1:0]           period;
        logic [N_CH-1:0][CNT_W-1:0] cmp;
        logic [N_CH-1:0]            pwm_en;
        logic [N_CH-1:0]            lvl;
        logic                       clr_en;
        logic [SEL_W-1:0]           clr_sel;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] pre;
    } ctr_t;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  pre_cnt,
    output logic [DATA_W-1:0] rd_data,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    cfg_d.run  = wr_data[0];
                    cfg_d.hold = wr_data[1];
                end
                A_PRE: cfg_d.pre_lim = wr_data[CNT_W-1:0];
                A_PER: cfg_d.period  = wr_data[CNT_W-1:0];
                A_PWM: cfg_d.pwm_en  = wr_data[N_CH-1:0];
                A_LVL: cfg_d.lvl     = wr_data[N_CH-1:0];
                A_CLR: begin
                    cfg_d.clr_en  = wr_data[0];
                    cfg_d.clr_sel = wr_data[SEL_W:1];
                end
                default: ;
            endcase
            for (int i = 0; i < N_CH; i++) begin
                if (wr_addr == ADDR_W'(int'(A_MATCH0) + i))
                    cfg_d.cmp[i] = wr_data[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: rd_data = DATA_W'({cfg_q.hold, cfg_q.run});
            A_PRE:  rd_data = DATA_W'(cfg_q.pre_lim);
            A_PER:  rd_data = DATA_W'(cfg_q.period);
            A_PWM:  rd_data = DATA_W'(cfg_q.pwm_en);
            A_LVL:  rd_data = DATA_W'(cfg_q.lvl);
            A_CLR:  rd_data = DATA_W'({cfg_q.clr_sel, cfg_q.clr_en});
            A_CNT:  rd_data = DATA_W'(count);
            A_PCNT: rd_data = DATA_W'(pre_cnt);
            default: ;
        endcase
        for (int i = 0; i < N_CH; i++) begin
            if (rd_addr == ADDR_W'(int'(A_MATCH0) + i))
                rd_data = DATA_W'(cfg_q.cmp[i]);
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pwm_timer_sync.sv
module pwm_timer_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    // stages 0..STAGES-1 synchronise, stage STAGES holds the previous value
    logic [STAGES:0][N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = pin;
        for (int k = 1; k <= STAGES; k++) pipe_d[k] = pipe_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
    import pwm_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic [N_CAP-1:0] rise,
    input  logic [N_CAP-1:0] fall,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] pre_cnt,
    output logic             cap_clr,
    output logic             zero_evt
);
    localparam int N_EDGE = 2 * N_CAP;

    ctr_t ctr_d, ctr_q;
    logic [N_EDGE-1:0] edges;
    logic [N_SEL-1:0]  edge_vec;
    logic              tick, wrap;

    // select code 2c+0 is rising edge of pin c, 2c+1 its falling edge
    for (genvar c = 0; c < N_CAP; c++) begin : g_edge
        assign edges[2*c]   = rise[c];
        assign edges[2*c+1] = fall[c];
    end
    assign edge_vec = N_SEL'(edges);
    assign cap_clr  = cfg.clr_en & edge_vec[cfg.clr_sel];

    always_comb begin
        ctr_d = ctr_q;
        tick  = cfg.run && (ctr_q.pre >= cfg.pre_lim);
        wrap  = tick && (ctr_q.count == cfg.period);
        if (cfg.hold || cap_clr) begin
            ctr_d = '0;
        end else if (cfg.run) begin
            if (tick) begin
                ctr_d.pre   = '0;
                ctr_d.count = wrap ? '0 : ctr_q.count + CNT_W'(1);
            end else begin
                ctr_d.pre = ctr_q.pre + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign count    = ctr_q.count;
    assign pre_cnt  = ctr_q.pre;
    assign zero_evt = cfg.hold || cap_clr || wrap;
endmodule

// File: rtl/pwm_timer_outs.sv
module pwm_timer_outs
    import pwm_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  cfg_t            cfg,
    input  logic [CNT_W-1:0] count,
    input  logic            zero_evt,
    output logic [N_CH-1:0] mat_out
);
    logic [N_CH-1:0] pwm_d, pwm_q;

    always_comb begin
        pwm_d = pwm_q;
        for (int i = 0; i < N_CH; i++) begin
            if (zero_evt)                 pwm_d[i] = 1'b0;
            else if (count == cfg.cmp[i]) pwm_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= '0;
        else        pwm_q <= pwm_d;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_mux
        assign mat_out[i] = cfg.pwm_en[i] ? pwm_q[i] : cfg.lvl[i];
    end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_CAP-1:0]  cap_in,
    output logic [N_CH-1:0]   mat_out
);
    cfg_t             cfg;
    logic [CNT_W-1:0] count, pre_cnt;
    logic [N_CAP-1:0] rise, fall;
    logic             cap_clr, zero_evt;

    pwm_timer_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .count(count),
        .pre_cnt(pre_cnt), .rd_data(rd_data), .cfg(cfg)
    );

    pwm_timer_sync #(.N(N_CAP), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise(rise), .fall(fall)
    );

    pwm_timer_core u_core (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .rise(rise), .fall(fall),
        .count(count), .pre_cnt(pre_cnt), .cap_clr(cap_clr), .zero_evt(zero_evt)
    );

    pwm_timer_outs u_outs (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .count(count),
        .zero_evt(zero_evt), .mat_out(mat_out)
    );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [N_CH-1:0]   mat_out,
    input cfg_t              cfg,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  pre_cnt,
    input logic              cap_clr,
    input logic              zero_evt
);
    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.run && !cfg.hold && !cap_clr && !wr_en && pre_cnt >= cfg.pre_lim
         && count != cfg.period) |=> count == $past(count) + CNT_W'(1));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.hold |=> (count == '0 && pre_cnt == '0));

    // R3
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.run && !cfg.hold && pre_cnt >= cfg.pre_lim && count == cfg.period)
        |=> count == '0);

    // R7
    pin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_clr |=> (count == '0 && pre_cnt == '0));

    // R8
    pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.clr_en && !wr_en && cfg.run && !cfg.hold && pre_cnt < cfg.pre_lim)
        |=> pre_cnt == $past(pre_cnt) + CNT_W'(1));

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // R4
        pwm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.pwm_en[i] && !wr_en && !zero_evt && count == cfg.cmp[i])
            |=> mat_out[i]);

        // R5
        pwm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.pwm_en[i] && !wr_en && zero_evt) |=> !mat_out[i]);

        // R6
        lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_LVL && !cfg.pwm_en[i])
            |=> (cfg.pwm_en[i] || mat_out[i] == $past(wr_data[i])));
    end
endmodule

bind pwm_timer pwm_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mat_out(mat_out), .cfg(cfg), .count(count),
    .pre_cnt(pre_cnt), .cap_clr(cap_clr), .zero_evt(zero_evt)
);

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;
    localparam int CLK_PER = 10;
    localparam int WD_CYC  = 50000;
    localparam int N_ROW   = 16;
    // each row: prescale limit, period, channel-0 compare, edges after run
    localparam int VEC [0:N_ROW-1][0:3] = '{
        '{0, 9, 4, 3},  '{0, 9, 4, 5},  '{0, 9, 4, 9},  '{0, 9, 4, 10},
        '{0, 9, 4, 15}, '{2, 5, 2, 7},  '{2, 5, 2, 9},  '{2, 5, 2, 10},
        '{2, 5, 2, 19}, '{1, 3, 0, 1},  '{1, 3, 0, 2},  '{1, 3, 0, 8},
        '{1, 3, 0, 9},  '{0, 5, 7, 4},  '{0, 5, 7, 6},  '{3, 2, 2, 14}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  cap_in = '0;
    logic [2:0]  mat_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    pwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .mat_out(mat_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    function automatic int cnt_at(int n, int p, int per);
        return (n / (p + 1)) % (per + 1);
    endfunction

    function automatic int out_at(int n, int p, int per, int m);
        int prev;
        if (n < 1) return 0;
        prev = cnt_at(n - 1, p, per);
        if ((n % (p + 1)) == 0 && prev == per) return 0;
        return (prev >= m) ? 1 : 0;
    endfunction

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 outputs", 32'(mat_out), 32'h0);
        for (int a = 0; a <= 10; a++) begin
            rd(4'(a), v);
            chk("R1 register", v, 32'h0);
        end

        // R2 R3 R4 R5 table of PWM runs on channel 0
        for (int r = 0; r < N_ROW; r++) begin
            wr(4'd0, 32'h2);
            wr(4'd1, 32'(VEC[r][0]));
            wr(4'd5, 32'(VEC[r][1]));
            wr(4'd2, 32'(VEC[r][2]));
            wr(4'd6, 32'h1);
            wr(4'd0, 32'h1);
            wait_edges(VEC[r][3]);
            rd(4'd9, v);
            chk("R2 R3 count", v, 32'(cnt_at(VEC[r][3], VEC[r][0], VEC[r][1])));
            chk("R4 R5 pwm out", 32'(mat_out[0]),
                32'(out_at(VEC[r][3], VEC[r][0], VEC[r][1], VEC[r][2])));
        end

        // R2 hold keeps counters at zero
        wr(4'd0, 32'h3);
        wait_edges(4);
        rd(4'd9, v);  chk("R2 hold count", v, 32'h0);
        rd(4'd10, v); chk("R2 hold prescale", v, 32'h0);

        // R6 level outputs
        wr(4'd6, 32'h0);
        wr(4'd7, 32'h5);
        @(negedge clk);
        chk("R6 level 101", 32'(mat_out), 32'h5);
        wr(4'd7, 32'h2);
        @(negedge clk);
        chk("R6 level 010", 32'(mat_out), 32'h2);

        // R9 unused bits
        wr(4'd6, 32'hFFFF_FFF8);
        @(negedge clk);
        rd(4'd6, v); chk("R9 pwm reg", v, 32'h0);
        chk("R9 outputs unchanged", 32'(mat_out), 32'h2);
        wr(4'd0, 32'hFFFF_FFFC);
        rd(4'd0, v); chk("R9 ctrl reg", v, 32'h0);
        wr(4'd8, 32'hFFFF_FFF0);
        rd(4'd8, v); chk("R9 clear reg", v, 32'h0);

        // R10 readback
        wr(4'd5, 32'h1234_5678);
        rd(4'd5, v); chk("R10 period", v, 32'h1234_5678);
        wr(4'd4, 32'h0000_CAFE);
        rd(4'd4, v); chk("R10 compare 2", v, 32'h0000_CAFE);
        wr(4'd8, 32'h7);
        rd(4'd8, v); chk("R10 clear setup", v, 32'h7);

        // R7 pin 0 rising clears, R5 output drops with it
        wr(4'd0, 32'h2);
        wr(4'd1, 32'h0);
        wr(4'd5, 32'd1000);
        wr(4'd2, 32'd5);
        wr(4'd6, 32'h1);
        wr(4'd8, 32'h1);
        wr(4'd0, 32'h1);
        wait_edges(20);
        chk("R4 high before clear", 32'(mat_out[0]), 32'h1);
        cap_in[0] = 1'b1;
        wait_edges(3);
        rd(4'd9, v); chk("R7 rise pin0 clears", v, 32'h0);
        chk("R5 pin clear drops pwm", 32'(mat_out[0]), 32'h0);
        wait_edges(1);
        rd(4'd9, v); chk("R7 count resumes", v, 32'h1);

        // R7 pin 0 falling clears
        wr(4'd8, 32'h3);
        wait_edges(5);
        cap_in[0] = 1'b0;
        wait_edges(3);
        rd(4'd9, v); chk("R7 fall pin0 clears", v, 32'h0);

        // R7 pin 1 rising clears count and prescaler
        wr(4'd0, 32'h2);
        wr(4'd1, 32'd3);
        wr(4'd8, 32'h5);
        wr(4'd0, 32'h1);
        wait_edges(10);
        cap_in[1] = 1'b1;
        wait_edges(3);
        rd(4'd9, v);  chk("R7 rise pin1 count", v, 32'h0);
        rd(4'd10, v); chk("R7 rise pin1 prescale", v, 32'h0);
        wait_edges(3);
        rd(4'd9, v);  chk("R7 prescale restarted", v, 32'h0);
        wait_edges(1);
        rd(4'd9, v);  chk("R7 first step", v, 32'h1);

        // R7 pin 1 falling clears
        wr(4'd1, 32'h0);
        wr(4'd8, 32'h7);
        wait_edges(5);
        cap_in[1] = 1'b0;
        wait_edges(3);
        rd(4'd9, v); chk("R7 fall pin1 clears", v, 32'h0);

        // R8 clear disabled
        wr(4'd8, 32'h4);
        wait_edges(4);
        rd(4'd9, v0);
        cap_in[1] = 1'b1;
        wait_edges(3);
        rd(4'd9, v); chk("R8 disabled no clear", v, v0 + 32'd3);

        // R8 reserved select codes
        wr(4'd8, 32'hB);
        wait_edges(4);
        rd(4'd9, v0);
        cap_in = 2'b01;
        wait_edges(3);
        rd(4'd9, v); chk("R8 select 5 no clear", v, v0 + 32'd3);
        wr(4'd8, 32'hF);
        wait_edges(4);
        rd(4'd9, v0);
        cap_in = 2'b10;
        wait_edges(3);
        rd(4'd9, v); chk("R8 select 7 no clear", v, v0 + 32'd3);

        // R8 enabled but edge on the other pin
        wr(4'd8, 32'h1);
        wait_edges(4);
        rd(4'd9, v0);
        cap_in = 2'b00;
        wait_edges(1);
        cap_in = 2'b10;
        wait_edges(2);
        rd(4'd9, v); chk("R8 other pin no clear", v, v0 + 32'd3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule